// File: doc/BRIEF.md
# Paged Fetch Address Generator

This block produces the instruction fetch address for a 16384-word program store. The store is split into eight pages of 2048 words each. The top three address bits pick the page and the low eleven bits pick the word within it. The address advances by one on every enabled fetch. A decoded branch-type code and an eleven-bit offset from the instruction decoder redirect it.

Unconditional jumps and subroutine calls do not carry a page number. They take the page from a small page register that software writes beforehand. Conditional branches and skips never leave the page they are in. Five interrupt sources each have a fixed entry address, and a fixed priority settles simultaneous requests. Reset starts execution at address zero.

Whenever a call or an interrupt is taken, the block raises a one-cycle push request with the resume address for an external return stack. A return takes the address the stack supplies.

Top module: `paged_pc_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` becomes 0, the page register becomes 0, and `push_req` and `irq_ack` become 0. All outputs are registered and change only at a rising clock edge after the cycle whose inputs they reflect.
- R2: With `fetch_en` low, `pc` holds, `push_req` and `irq_ack` are 0, and both `br_kind` and `irq_req` are ignored.
- R3: With `fetch_en` high, no interrupt request, and `br_kind` equal to 0, 6 or 7, `pc` advances by one modulo 16384. 3FFFH wraps to 0000H.
- R4: `br_kind` = 1 (jump) loads `pc` with the page register in bits 13:11 and `br_off` in bits 10:0, with no push. The page used is the one stored before that edge, even when `pg_wr` is high in the same cycle.
- R5: `br_kind` = 2 (call) loads the same target as a jump. It also pulses `push_req` for one cycle, with `push_addr` equal to the calling address plus one modulo 16384.
- R6: `br_kind` = 3 (taken conditional branch) keeps `pc` bits 13:11 and replaces bits 10:0 with `br_off`.
- R7: `br_kind` = 4 (skip) keeps `pc` bits 13:11 and adds 2 to bits 10:0 modulo 2048, so the skip wraps inside the page.
- R8: `br_kind` = 5 (return) loads `pc` with `ret_addr`, without a push.
- R9: When `pg_wr` is high at an edge, the page register takes `pg_data`. This happens whether `fetch_en` is high or low.
- R10: With `fetch_en` high and any `irq_req` bit set, the lowest-numbered requesting source wins. `pc` loads its vector (source 0: 0004H, 1: 0008H, 2: 000CH, 3: 0014H, 4: 0020H), whatever `br_kind` is. `push_req` pulses with `push_addr` equal to the interrupted `pc`.
- R11: `irq_ack` is a one-cycle pulse, one-hot on the bit of the source taken, and all zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Advance the fetch address this cycle |
| br_kind | input | 3 | Decoded flow type: 0 sequential, 1 jump, 2 call, 3 conditional, 4 skip, 5 return |
| br_off | input | 11 | In-page target offset |
| pg_wr | input | 1 | Write strobe for the page register |
| pg_data | input | 3 | New page number |
| irq_req | input | 5 | Interrupt requests, bit 0 highest priority |
| ret_addr | input | 14 | Return address from the stack top |
| pc | output | 14 | Current fetch address |
| push_req | output | 1 | One-cycle request to push `push_addr` |
| push_addr | output | 14 | Resume address to push |
| irq_ack | output | 5 | One-hot acknowledge of the source taken |

## Verification
On every cycle, the bound checker confirms the following: a stalled fetch leaves the address frozen with no push or acknowledge, sequential steps add one, conditional branches and skips keep the page bits, any accepted request produces both a push and a one-hot acknowledge, and returns copy the stack address. Some behaviour depends on stored state or on the exact vector chosen. This includes the page register's value and its old-value timing against a same-cycle write, the priority among all 31 request patterns, and the wrap at the top of memory. Only the bench's sweeps can show these, because it compares against its own arithmetic model.

// File: rtl/pcgen_pkg.sv
package pcgen_pkg;

  typedef enum logic [2:0] {
    BK_SEQ  = 3'd0,
    BK_JUMP = 3'd1,
    BK_CALL = 3'd2,
    BK_COND = 3'd3,
    BK_SKIP = 3'd4,
    BK_RET  = 3'd5
  } br_kind_e;

  localparam int VEC_W = 16;

  // Entry address per interrupt source; index order is priority order.
  function automatic logic [VEC_W-1:0] irq_vector(input int unsigned idx);
    logic [VEC_W-1:0] v;
    case (idx)
      0:       v = 16'h0004;
      1:       v = 16'h0008;
      2:       v = 16'h000C;
      3:       v = 16'h0014;
      4:       v = 16'h0020;
      default: v = 16'h0000;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/pcgen_irq_arb.sv
module pcgen_irq_arb #(
  parameter int N_SRC = 5,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req,
  output logic [N_SRC-1:0] grant,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // Lower index wins: each grant is masked by every lower request.
  genvar gi;
  generate
    for (gi = 0; gi < N_SRC; gi++) begin : g_grant
      if (gi == 0) begin : g_top
        assign grant[gi] = req[gi];
      end else begin : g_rest
        assign grant[gi] = req[gi] & ~(|req[gi-1:0]);
      end
    end
  endgenerate

  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/pcgen_page_reg.sv
module pcgen_page_reg #(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [PAGE_W-1:0] wdata,
  output logic [PAGE_W-1:0] page_q
);

  always_ff @(posedge clk) begin
    if (rst)     page_q <= '0;
    else if (wr) page_q <= wdata;
  end

endmodule

// File: rtl/pcgen_next_mux.sv
module pcgen_next_mux
  import pcgen_pkg::*;
#(
  parameter int PC_W   = 14,
  parameter int PAGE_W = 3,
  parameter int N_SRC  = 5,
  localparam int OFF_W = PC_W - PAGE_W,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [PC_W-1:0]   pc_q,
  input  logic [PAGE_W-1:0] page_q,
  input  logic [2:0]        kind,
  input  logic [OFF_W-1:0]  off,
  input  logic [PC_W-1:0]   ret_addr,
  input  logic              irq_any,
  input  logic [IDX_W-1:0]  irq_idx,
  output logic [PC_W-1:0]   pc_next,
  output logic              push,
  output logic [PC_W-1:0]   push_val
);

  logic [PAGE_W-1:0] cur_page;
  logic [OFF_W-1:0]  cur_off;
  logic [PC_W-1:0]   pc_inc;
  logic [PC_W-1:0]   far_tgt;
  logic [PC_W-1:0]   near_tgt;
  logic [PC_W-1:0]   skip_tgt;
  logic [VEC_W-1:0]  vec_full;

  assign cur_page = pc_q[PC_W-1:OFF_W];
  assign cur_off  = pc_q[OFF_W-1:0];
  assign pc_inc   = pc_q + PC_W'(1);
  assign far_tgt  = {page_q, off};
  assign near_tgt = {cur_page, off};
  assign skip_tgt = {cur_page, OFF_W'(cur_off + OFF_W'(2))};
  assign vec_full = irq_vector(32'(irq_idx));

  always_comb begin
    pc_next  = pc_inc;
    push     = 1'b0;
    push_val = pc_inc;
    if (irq_any) begin
      pc_next  = vec_full[PC_W-1:0];
      push     = 1'b1;
      push_val = pc_q;
    end else begin
      case (br_kind_e'(kind))
        BK_JUMP: pc_next = far_tgt;
        BK_CALL: begin
          pc_next = far_tgt;
          push    = 1'b1;
        end
        BK_COND: pc_next = near_tgt;
        BK_SKIP: pc_next = skip_tgt;
        BK_RET:  pc_next = ret_addr;
        default: pc_next = pc_inc;
      endcase
    end
  end

endmodule

// File: rtl/paged_pc_gen.sv
module paged_pc_gen #(
  parameter int PC_W   = 14,
  parameter int PAGE_W = 3,
  parameter int N_SRC  = 5,
  localparam int OFF_W = PC_W - PAGE_W,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_en,
  input  logic [2:0]        br_kind,
  input  logic [OFF_W-1:0]  br_off,
  input  logic              pg_wr,
  input  logic [PAGE_W-1:0] pg_data,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic [PC_W-1:0]   ret_addr,
  output logic [PC_W-1:0]   pc,
  output logic              push_req,
  output logic [PC_W-1:0]   push_addr,
  output logic [N_SRC-1:0]  irq_ack
);

  logic [PAGE_W-1:0] page_q;
  logic [N_SRC-1:0]  grant;
  logic              irq_any;
  logic [IDX_W-1:0]  irq_idx;
  logic [PC_W-1:0]   pc_next;
  logic              push_next;
  logic [PC_W-1:0]   push_val;

  pcgen_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk   (clk),
    .rst   (rst),
    .wr    (pg_wr),
    .wdata (pg_data),
    .page_q(page_q)
  );

  pcgen_irq_arb #(.N_SRC(N_SRC)) u_arb (
    .req  (irq_req),
    .grant(grant),
    .any  (irq_any),
    .idx  (irq_idx)
  );

  pcgen_next_mux #(.PC_W(PC_W), .PAGE_W(PAGE_W), .N_SRC(N_SRC)) u_mux (
    .pc_q    (pc),
    .page_q  (page_q),
    .kind    (br_kind),
    .off     (br_off),
    .ret_addr(ret_addr),
    .irq_any (irq_any),
    .irq_idx (irq_idx),
    .pc_next (pc_next),
    .push    (push_next),
    .push_val(push_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      push_req  <= 1'b0;
      push_addr <= '0;
      irq_ack   <= '0;
    end else if (fetch_en) begin
      pc       <= pc_next;
      push_req <= push_next;
      irq_ack  <= grant;
      if (push_next) push_addr <= push_val;
    end else begin
      push_req <= 1'b0;
      irq_ack  <= '0;
    end
  end

endmodule

// File: rtl/paged_pc_gen_chk.sv
module paged_pc_gen_chk #(
  parameter int PC_W   = 14,
  parameter int PAGE_W = 3,
  parameter int N_SRC  = 5,
  localparam int OFF_W = PC_W - PAGE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_en,
  input logic [2:0]        br_kind,
  input logic [OFF_W-1:0]  br_off,
  input logic [N_SRC-1:0]  irq_req,
  input logic [PC_W-1:0]   ret_addr,
  input logic [PC_W-1:0]   pc,
  input logic              push_req,
  input logic [N_SRC-1:0]  irq_ack
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc == '0 && !push_req && irq_ack == '0));

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_en |=> ($stable(pc) && !push_req && irq_ack == '0));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && irq_req == '0 && (br_kind == 3'd0 || br_kind > 3'd5))
      |=> pc == PC_W'($past(pc) + PC_W'(1)));

  // R6
  cond_page_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && irq_req == '0 && br_kind == 3'd3)
      |=> (pc[PC_W-1:OFF_W] == $past(pc[PC_W-1:OFF_W]) &&
           pc[OFF_W-1:0] == $past(br_off)));

  // R7
  skip_page_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && irq_req == '0 && br_kind == 3'd4)
      |=> pc[PC_W-1:OFF_W] == $past(pc[PC_W-1:OFF_W]));

  // R8
  ret_load_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && irq_req == '0 && br_kind == 3'd5)
      |=> (pc == $past(ret_addr) && !push_req));

  // R10
  irq_push_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && irq_req != '0) |=> (push_req && irq_ack != '0));

  // R11
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_ack));

  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack != '0) |-> $past(fetch_en && irq_req != '0));

endmodule

bind paged_pc_gen paged_pc_gen_chk #(.PC_W(PC_W), .PAGE_W(PAGE_W), .N_SRC(N_SRC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .fetch_en(fetch_en),
  .br_kind (br_kind),
  .br_off  (br_off),
  .irq_req (irq_req),
  .ret_addr(ret_addr),
  .pc      (pc),
  .push_req(push_req),
  .irq_ack (irq_ack)
);

// File: tb/paged_pc_gen_tb.sv
module paged_pc_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_en = 1'b0;
  logic [2:0]  br_kind = 3'd0;
  logic [10:0] br_off = '0;
  logic        pg_wr = 1'b0;
  logic [2:0]  pg_data = '0;
  logic [4:0]  irq_req = '0;
  logic [13:0] ret_addr = '0;
  logic [13:0] pc;
  logic        push_req;
  logic [13:0] push_addr;
  logic [4:0]  irq_ack;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [13:0] e_pc;
  logic [2:0]  e_page;

  always #10 clk = ~clk;

  paged_pc_gen u_dut (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .br_kind(br_kind),
    .br_off(br_off), .pg_wr(pg_wr), .pg_data(pg_data), .irq_req(irq_req),
    .ret_addr(ret_addr), .pc(pc), .push_req(push_req),
    .push_addr(push_addr), .irq_ack(irq_ack)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [13:0] vec_of(input int i);
    if (i < 3) return 14'(4 * (i + 1));
    else if (i == 3) return 14'd20;
    else return 14'd32;
  endfunction

  // One enabled/disabled step; model computed arithmetically.
  task automatic step(input string req, input bit en, input logic [2:0] k,
                      input logic [10:0] off, input bit pw, input logic [2:0] pd,
                      input logic [4:0] irq, input logic [13:0] ra);
    logic [13:0] n_pc;
    logic        n_push;
    logic [13:0] n_paddr;
    logic [4:0]  n_ack;
    @(negedge clk);
    fetch_en = en; br_kind = k; br_off = off; pg_wr = pw; pg_data = pd;
    irq_req = irq; ret_addr = ra;
    n_pc = e_pc; n_push = 1'b0; n_paddr = '0; n_ack = '0;
    if (en) begin
      if (irq != 0) begin
        for (int i = 4; i >= 0; i--) begin
          if (irq[i]) begin
            n_pc = vec_of(i);
            n_ack = 5'(1 << i);
          end
        end
        n_push = 1'b1; n_paddr = e_pc;
      end else begin
        case (k)
          3'd1: n_pc = {e_page, off};
          3'd2: begin n_pc = {e_page, off}; n_push = 1'b1; n_paddr = 14'((e_pc + 1) % 16384); end
          3'd3: n_pc = {e_pc[13:11], off};
          3'd4: n_pc = {e_pc[13:11], 11'((e_pc[10:0] + 2) % 2048)};
          3'd5: n_pc = ra;
          default: n_pc = 14'((e_pc + 1) % 16384);
        endcase
      end
    end
    if (pw) e_page = pd;
    e_pc = n_pc;
    @(posedge clk);
    #2;
    chk(req, "pc", 16'(pc), 16'(n_pc));
    chk(req, "push_req", 16'(push_req), 16'(n_push));
    if (n_push) chk(req, "push_addr", 16'(push_addr), 16'(n_paddr));
    chk(req, "irq_ack", 16'(irq_ack), 16'(n_ack));
  endtask

  initial begin
    #(64'd200000 * 20);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    e_pc = '0; e_page = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1", "pc", 16'(pc), 16'h0);
    chk("R1", "push_req", 16'(push_req), 16'h0);
    chk("R1", "irq_ack", 16'(irq_ack), 16'h0);
    @(negedge clk); rst = 1'b0;
    // R1 page register reset: jump lands in page 0
    step("R1", 1, 3'd1, 11'h155, 0, 3'd0, 5'd0, 14'd0);

    // R9 / R4 page sweep
    for (int p = 0; p < 8; p++) begin
      step("R9", 1, 3'd0, 11'd0, 1, 3'(p), 5'd0, 14'd0);
      step("R4", 1, 3'd1, 11'(p * 37 + 5), 0, 3'd0, 5'd0, 14'd0);
    end
    // R4 same-cycle write uses stored page
    step("R9", 1, 3'd0, 11'd0, 1, 3'd3, 5'd0, 14'd0);
    step("R4", 1, 3'd1, 11'h7A, 1, 3'd6, 5'd0, 14'd0);
    step("R4", 1, 3'd1, 11'h7B, 0, 3'd0, 5'd0, 14'd0);

    // R3 sequential and top wrap
    step("R9", 1, 3'd0, 11'd0, 1, 3'd7, 5'd0, 14'd0);
    step("R4", 1, 3'd1, 11'h7FD, 0, 3'd0, 5'd0, 14'd0);
    for (int i = 0; i < 4; i++) step("R3", 1, 3'd0, 11'd0, 0, 3'd0, 5'd0, 14'd0);
    step("R3", 1, 3'd6, 11'd0, 0, 3'd0, 5'd0, 14'd0);
    step("R3", 1, 3'd7, 11'd0, 0, 3'd0, 5'd0, 14'd0);

    // R6 conditional across pages and offsets
    for (int p = 0; p < 8; p++) begin
      step("R9", 1, 3'd0, 11'd0, 1, 3'(p), 5'd0, 14'd0);
      step("R4", 1, 3'd1, 11'h400, 0, 3'd0, 5'd0, 14'd0);
      step("R6", 1, 3'd3, 11'h7FF, 0, 3'd0, 5'd0, 14'd0);
      step("R6", 1, 3'd3, 11'h000, 1, 3'(7 - p), 5'd0, 14'd0);
    end

    // R7 skip, including in-page wrap
    step("R9", 1, 3'd0, 11'd0, 1, 3'd5, 5'd0, 14'd0);
    step("R4", 1, 3'd1, 11'h7FC, 0, 3'd0, 5'd0, 14'd0);
    for (int i = 0; i < 4; i++) step("R7", 1, 3'd4, 11'd0, 0, 3'd0, 5'd0, 14'd0);
    step("R3", 1, 3'd0, 11'd0, 0, 3'd0, 5'd0, 14'd0);
    step("R7", 1, 3'd4, 11'd0, 0, 3'd0, 5'd0, 14'd0);
    step("R7", 1, 3'd4, 11'd0, 0, 3'd0, 5'd0, 14'd0);

    // R5 call and R8 return
    step("R9", 1, 3'd0, 11'd0, 1, 3'd2, 5'd0, 14'd0);
    step("R5", 1, 3'd2, 11'h123, 0, 3'd0, 5'd0, 14'd0);
    step("R3", 1, 3'd0, 11'd0, 0, 3'd0, 5'd0, 14'd0);
    step("R8", 1, 3'd5, 11'd0, 0, 3'd0, 5'd0, 14'h2ABC);
    step("R8", 1, 3'd5, 11'd0, 0, 3'd0, 5'd0, 14'h3FFF);
    step("R5", 1, 3'd2, 11'h7FF, 0, 3'd0, 5'd0, 14'd0);

    // R2 stall ignores kind and interrupts; R9 writes still land
    step("R2", 0, 3'd1, 11'h111, 0, 3'd0, 5'h1F, 14'd0);
    step("R2", 0, 3'd2, 11'h222, 1, 3'd4, 5'h02, 14'd0);
    step("R2", 0, 3'd5, 11'h333, 0, 3'd0, 5'd0, 14'h1234);
    step("R9", 1, 3'd1, 11'h044, 0, 3'd0, 5'd0, 14'd0);

    // R10 / R11 every request pattern
    for (int m = 1; m < 32; m++) begin
      step("R10", 1, 3'(m % 6), 11'(m * 13), 0, 3'd0, 5'(m), 14'h0AAA);
      step("R11", 1, 3'd0, 11'd0, 0, 3'd0, 5'd0, 14'd0);
    end

    // R1 reset mid-run clears pc and page
    @(negedge clk); rst = 1'b1; fetch_en = 1'b1; irq_req = 5'h1;
    @(posedge clk); #2;
    chk("R1", "pc", 16'(pc), 16'h0);
    chk("R1", "irq_ack", 16'(irq_ack), 16'h0);
    @(negedge clk); rst = 1'b0; irq_req = '0;
    e_pc = '0; e_page = '0;
    step("R1", 1, 3'd1, 11'h0F0, 0, 3'd0, 5'd0, 14'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule